// File: doc/BRIEF.md
# Arbitrary-Length CRC-8 Generator

This block computes an 8-bit cyclic redundancy check over a message whose length is given in bits. The length does not have to be a whole number of bytes. The message arrives as a stream of bytes, most significant bit first. One byte is absorbed on each clock cycle in which the valid strobe is high. Short command frames of odd bit lengths, such as a 12-bit page request or a 37-bit selection frame, can be protected with the same engine that handles whole-byte payloads.

A start pulse loads the total bit length and presets the remainder register. The block then accepts bytes until the length is used up. The final byte may be partial: only its leading bits are stepped through the polynomial. When the last byte has been absorbed, the block raises a done flag. The checksum and the flag then stay fixed until the next start pulse. The result is the raw register contents, with no output inversion and no bit reversal.

Top module: `bitlen_crc8`

## Requirements
- R1: After reset, `crc` reads 0xFF and `done` is low.
- R2: A `start` pulse presets `crc` to 0xFF and clears `done` on that clock edge. A byte offered with `in_valid` in the same cycle as `start` is ignored.
- R3: Each accepted byte is XORed into the register. The register then takes one step per bit: a left shift, plus an XOR with polynomial 0x1D if bit 7 was set before the shift. A byte that is not the final partial byte gets 8 steps. No final XOR or reflection is applied.
- R4: When `len_bits` is not a multiple of 8, the final byte is still XORed in whole, but only `len_bits mod 8` steps are applied to it. The meaningful bits are the leading (most significant) bits of that byte. Lengths of 12 and 37 bits are supported.
- R5: A `start` with `len_bits` equal to 0 raises `done` on the same edge, and `crc` reads 0xFF.
- R6: `done` stays low while bytes remain. It rises on the clock edge that absorbs the final byte, and the final `crc` value appears on that same edge. The message takes ceil(len_bits/8) accepted bytes.
- R7: Once `done` is high, `done` and `crc` hold and further `in_valid` bytes are ignored, until the next `start`.
- R8: Cycles with `in_valid` low do not change the register, whatever `in_byte` carries.
- R9: A `start` issued partway through a message discards the partial result and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new message; loads the length and presets the register |
| len_bits | input | LEN_W | Message length in bits, sampled when `start` is high |
| in_valid | input | 1 | The current `in_byte` belongs to the message |
| in_byte | input | 8 | Message byte, most significant bit sent first |
| crc | output | 8 | Current register value; the checksum once `done` is high |
| done | output | 1 | All bits of the message have been absorbed |

## Verification
A wrong step count on the final partial byte, a missed polynomial XOR or a stray extra shift changes `crc` on the edge that raises `done`. Because the bench compares `crc` one half cycle after that edge, such a fault appears on the first message whose length or data exercises it. A fault in the remaining-bit counter shows up in the timing of `done`: the flag rises one byte early, one byte late, or never. The bench catches this by checking `done` just before the final byte and just after it. A fault that lets a byte through while the block is idle, finished, or starting would change a held `crc` within one cycle. The bench probes for this after every message.

// File: rtl/bitlen_crc8.sv
module bitlen_crc8 #(
  parameter int         LEN_W = 16,
  parameter logic [7:0] POLY  = 8'h1D,
  parameter logic [7:0] INIT  = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_bits,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic [7:0]       crc,
  output logic             done
);
  localparam int BYTE_BITS = 8;
  localparam int STEP_W    = $clog2(BYTE_BITS + 1);

  logic [LEN_W-1:0]  rem_q;
  logic              busy_q, done_q;
  logic [7:0]        crc_q, crc_nxt;
  logic              last_byte;
  logic [STEP_W-1:0] n_steps;

  assign last_byte = rem_q <= LEN_W'(BYTE_BITS);
  assign n_steps   = last_byte ? STEP_W'(rem_q) : STEP_W'(BYTE_BITS);

  always_comb begin
    crc_nxt = crc_q ^ in_byte;
    for (int i = 0; i < BYTE_BITS; i++) begin
      if (STEP_W'(i) < n_steps)
        crc_nxt = crc_nxt[7] ? ((crc_nxt << 1) ^ POLY) : (crc_nxt << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= INIT;
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      crc_q  <= INIT;
      rem_q  <= len_bits;
      busy_q <= len_bits != '0;
      done_q <= len_bits == '0;
    end else if (busy_q && in_valid) begin
      crc_q <= crc_nxt;
      if (last_byte) begin
        rem_q  <= '0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        rem_q <= rem_q - LEN_W'(BYTE_BITS);
      end
    end
  end

  assign crc  = crc_q;
  assign done = done_q;

  assert_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc == INIT) && !busy_q || (crc == INIT));

  assert_empty_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start && (len_bits == '0) |=> done && (crc == INIT));

  assert_clear_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && (len_bits != '0) |=> !done);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid) || $past(start));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(crc));

  assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !start |=> $stable(crc));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy_q));
endmodule

// File: tb/bitlen_crc8_test.sv
module bitlen_crc8_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [LEN_W-1:0] len_bits = '0;
  logic [7:0] in_byte = '0, crc;
  logic done;
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] msg [32];

  bitlen_crc8 #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_bits(len_bits),
    .in_valid(in_valid), .in_byte(in_byte), .crc(crc), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_crc(int len);
    logic [7:0] r = 8'hFF;
    int nb = (len + 7) / 8;
    for (int b = 0; b < nb; b++) begin
      int steps = (len < 8*(b+1)) ? (len % 8) : 8;
      r ^= msg[b];
      for (int s = 0; s < steps; s++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_msg(int len, int abort_after);
    int nb = (len + 7) / 8;
    logic [7:0] held;
    @(negedge clk);
    start = 1'b1; len_bits = LEN_W'(len);
    in_valid = 1'b1; in_byte = 8'($urandom);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    check("R2 crc preset", crc, 8'hFF);
    if (abort_after < 0) check("R5/R2 done after start", done, (len == 0));
    for (int b = 0; b < nb; b++) begin
      if (abort_after >= 0 && b == abort_after) return;
      repeat ($urandom_range(0, 2)) begin
        in_byte = 8'($urandom);
        @(negedge clk);
      end
      if (b == nb - 1) check("R6 done low before last byte", done, 1'b0);
      in_valid = 1'b1; in_byte = msg[b];
      @(negedge clk);
      in_valid = 1'b0;
    end
    check("R6 done after last byte", done, 1'b1);
    if (len % 8 != 0) check("R4 partial final byte crc", crc, ref_crc(len));
    else check("R3 whole byte crc", crc, ref_crc(len));
    held = crc;
    in_valid = 1'b1;
    repeat (3) begin
      in_byte = 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R7 crc held after done", crc, held);
    check("R7 done held", done, 1'b1);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 32; i++) msg[i] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (2) @(negedge clk);
    check("R1 crc reset", crc, 8'hFF);
    check("R1 done reset", done, 1'b0);
    rst_n = 1'b1;
    in_valid = 1'b1; in_byte = 8'hA5;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 idle byte ignored", crc, 8'hFF);
    run_msg(0, -1);
    check("R5 zero length crc", crc, 8'hFF);
    msg[0] = 8'hC1; msg[1] = 8'h20;
    run_msg(12, -1);
    msg[0] = 8'h01; msg[1] = 8'h23; msg[2] = 8'h45; msg[3] = 8'h67; msg[4] = 8'h88;
    run_msg(37, -1);
    msg[0] = 8'h80; run_msg(1, -1);
    msg[0] = 8'hFE; run_msg(7, -1);
    msg[0] = 8'h00; run_msg(8, -1);
    msg[0] = 8'hFF; msg[1] = 8'h00; run_msg(16, -1);
    fill_random();
    run_msg(100, 5);
    run_msg(100, -1);
    check("R9 restart discards partial", crc, ref_crc(100));
    for (int k = 0; k < 40; k++) begin
      fill_random();
      run_msg($urandom_range(1, 255), -1);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule